// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the boundary between the decode stage and the execute stage of a five-stage in-order pipeline. It takes the two source register numbers of the instruction now in decode. It also takes the destination register number and the memory-read flag of the instruction now in execute. When a load in execute writes a register that the decode instruction reads, forwarding cannot deliver the value in time. The unit then asks the pipeline for a one-cycle stall.

A stall has two parts. The PC and the fetch/decode pipeline register are frozen, so the same instruction is decoded again and the one after it is fetched again. At the same time, a zero-control select makes the decode/execute register take a bubble whose control fields are all cleared. One cycle later the load has left execute and the bubble has no memory-read flag, so the stall releases by itself. The load value then reaches the consumer through the forwarding path from the memory/writeback register. Every other dependency is left to forwarding. The unit is purely combinational, so its outputs apply in the same cycle as the register fields they are computed from.

Top module: `hazard_stall_unit`

## Requirements
- R1: With the execute memory-read flag high and a nonzero execute destination equal to the decode first source, the unit stalls: pc_write_o=0, ifid_write_o=0, ctrl_zero_o=1.
- R2: With the execute memory-read flag high and a nonzero execute destination equal to the decode second source, the unit stalls in the same way as in R1.
- R3: With the execute memory-read flag low, no stall is raised whatever the register numbers are: pc_write_o=1, ifid_write_o=1, ctrl_zero_o=0.
- R4: An execute destination of register zero never raises a stall, even if a decode source is also zero.
- R5: A load whose destination matches neither decode source raises no stall.
- R6: The three outputs always agree: pc_write_o equals ifid_write_o, and ctrl_zero_o is their inverse.
- R7: Inside a pipeline that applies the outputs, a load followed at once by a dependent instruction costs exactly one stall cycle, never two in a row, and instructions still enter execute in program order with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a_i | input | 5 | First source register number of the instruction in decode |
| dec_src_b_i | input | 5 | Second source register number of the instruction in decode |
| exe_dst_i | input | 5 | Load destination register number held for the instruction in execute |
| exe_mem_rd_i | input | 1 | Memory-read flag of the instruction in execute |
| pc_write_o | output | 1 | PC update enable, low during a stall |
| ifid_write_o | output | 1 | Fetch/decode register update enable, low during a stall |
| ctrl_zero_o | output | 1 | High to load a cleared-control bubble into the decode/execute register |

## Verification
A single output vector cannot show the hardest property, R7: a stall must release after one cycle and must not drop or repeat an instruction. That property only appears when the outputs are fed back into pipeline registers. The bench therefore builds a small behavioural fetch/decode/execute model around the unit. It runs generated programs with planted load-use pairs through that model, and compares the stall count and the order in which instructions enter execute with values worked out from the program text. Random and directed register vectors cover the per-case decode conditions, including register zero and matches on both sources at once.

// File: rtl/hsu_pkg.sv
package hsu_pkg;

    // Front-end control produced by the stall unit
    typedef struct packed {
        logic pc_write;
        logic ifid_write;
        logic ctrl_zero;
    } front_ctl_t;

    // Control value used when no hazard is present
    localparam front_ctl_t FRONT_RUN   = '{pc_write: 1'b1, ifid_write: 1'b1, ctrl_zero: 1'b0};
    // Control value used to freeze fetch/decode and inject a bubble
    localparam front_ctl_t FRONT_STALL = '{pc_write: 1'b0, ifid_write: 1'b0, ctrl_zero: 1'b1};

endpackage

// File: rtl/hsu_src_match.sv
// Compares one decode source operand with the load destination in execute.
module hsu_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] dst_i,
    output logic             hit_o
);
    logic dst_live;

    always_comb begin
        // Register zero is hardwired and never carries a produced value
        dst_live = (dst_i != '0);
        hit_o    = dst_live && (src_i == dst_i);
    end
endmodule

// File: rtl/hsu_ctl_gen.sv
// Turns the per-source match vector and the load flag into front-end control.
module hsu_ctl_gen
    import hsu_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] hit_i,
    input  logic               mem_rd_i,
    output front_ctl_t         ctl_o
);
    logic       any_hit;
    front_ctl_t ctl_d;

    always_comb begin
        any_hit = |hit_i;
        ctl_d   = FRONT_RUN;
        if (mem_rd_i && any_hit) begin
            ctl_d = FRONT_STALL;
        end
        ctl_o = ctl_d;
    end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
    import hsu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dec_src_a_i,
    input  logic [REG_W-1:0] dec_src_b_i,
    input  logic [REG_W-1:0] exe_dst_i,
    input  logic             exe_mem_rd_i,
    output logic             pc_write_o,
    output logic             ifid_write_o,
    output logic             ctrl_zero_o
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
    logic [NUM_SRC-1:0]            hit_vec;
    front_ctl_t                    ctl_d;

    always_comb begin
        src_vec[0] = dec_src_a_i;
        src_vec[1] = dec_src_b_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hsu_src_match #(.REG_W(REG_W)) u_match (
            .src_i (src_vec[g]),
            .dst_i (exe_dst_i),
            .hit_o (hit_vec[g])
        );
    end

    hsu_ctl_gen #(.NUM_SRC(NUM_SRC)) u_ctl (
        .hit_i    (hit_vec),
        .mem_rd_i (exe_mem_rd_i),
        .ctl_o    (ctl_d)
    );

    always_comb begin
        pc_write_o   = ctl_d.pc_write;
        ifid_write_o = ctl_d.ifid_write;
        ctrl_zero_o  = ctl_d.ctrl_zero;
    end
endmodule

// File: rtl/hsu_chk.sv
module hsu_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] dec_src_a_i,
    input logic [REG_W-1:0] dec_src_b_i,
    input logic [REG_W-1:0] exe_dst_i,
    input logic             exe_mem_rd_i,
    input logic             pc_write_o,
    input logic             ifid_write_o,
    input logic             ctrl_zero_o
);
    always_comb begin
        // R1
        if (exe_mem_rd_i && exe_dst_i != '0 && exe_dst_i == dec_src_a_i)
            src_a_stall_chk: assert (ctrl_zero_o && !pc_write_o);
        // R2
        if (exe_mem_rd_i && exe_dst_i != '0 && exe_dst_i == dec_src_b_i)
            src_b_stall_chk: assert (ctrl_zero_o && !ifid_write_o);
        // R3
        if (!exe_mem_rd_i)
            no_load_run_chk: assert (pc_write_o && !ctrl_zero_o);
        // R4
        if (exe_dst_i == '0)
            zero_dst_run_chk: assert (ifid_write_o && !ctrl_zero_o);
        // R5
        if (exe_dst_i != dec_src_a_i && exe_dst_i != dec_src_b_i)
            no_match_run_chk: assert (pc_write_o && ifid_write_o);
        // R6
        outputs_agree_chk: assert (pc_write_o == ifid_write_o && ctrl_zero_o == !pc_write_o);
    end
endmodule

bind hazard_stall_unit hsu_chk #(.REG_W(REG_W)) u_hsu_chk (
    .dec_src_a_i  (dec_src_a_i),
    .dec_src_b_i  (dec_src_b_i),
    .exe_dst_i    (exe_dst_i),
    .exe_mem_rd_i (exe_mem_rd_i),
    .pc_write_o   (pc_write_o),
    .ifid_write_o (ifid_write_o),
    .ctrl_zero_o  (ctrl_zero_o)
);

// File: tb/sim_hazard_stall_unit.sv
module sim_hazard_stall_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_LEN   = 60;

    logic       clk = 1'b0;
    logic [4:0] src_a, src_b, dst;
    logic       mem_rd;
    logic       pc_w, ifid_w, czero;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_stall_unit u0 (
        .dec_src_a_i  (src_a),
        .dec_src_b_i  (src_b),
        .exe_dst_i    (dst),
        .exe_mem_rd_i (mem_rd),
        .pc_write_o   (pc_w),
        .ifid_write_o (ifid_w),
        .ctrl_zero_o  (czero)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference: stall when a load writes a nonzero register read in decode
    function automatic bit ref_stall(logic [4:0] a, logic [4:0] b, logic [4:0] d, logic m);
        return m && (d != 0) && (d == a || d == b);
    endfunction

    function automatic string req_of(logic [4:0] a, logic [4:0] b, logic [4:0] d, logic m);
        if (!m) return "R3";
        if (d == 0) return "R4";
        if (d == a) return "R1";
        if (d == b) return "R2";
        return "R5";
    endfunction

    task automatic apply_vec(logic [4:0] a, logic [4:0] b, logic [4:0] d, logic m);
        logic [2:0] exp_v, act_v;
        bit st;
        @(posedge clk); #1;
        src_a = a; src_b = b; dst = d; mem_rd = m;
        @(negedge clk);
        st    = ref_stall(a, b, d, m);
        exp_v = st ? 3'b001 : 3'b110;
        act_v = {pc_w, ifid_w, czero};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s/R6 a=%0d b=%0d d=%0d m=%0b: actual=%b expected=%b",
                     req_of(a, b, d, m), a, b, d, m, act_v, exp_v);
        end
    endtask

    // Instruction for the pipeline model
    typedef struct {
        bit         is_load;
        logic [4:0] ra;
        logic [4:0] rb;
        logic [4:0] wd;
        int         idx;
    } instr_t;

    task automatic run_program(int seed_mode);
        instr_t prog[$];
        instr_t ifid, idex, bub;
        int     issued[$];
        int     exp_stalls = 0;
        int     got_stalls = 0;
        int     pc = 0;
        bit     prev_stall = 0;
        int     back_to_back = 0;
        bit     order_ok = 1;
        instr_t ins;

        for (int i = 0; i < PROG_LEN; i++) begin
            ins.is_load = ($urandom_range(0, 2) == 0);
            ins.ra  = 5'($urandom_range(0, 7));
            ins.rb  = 5'($urandom_range(0, 7));
            ins.wd  = 5'($urandom_range(0, 7));
            ins.idx = i;
            if (i > 0 && prog[i-1].is_load && seed_mode == 1 && (i % 3 == 0))
                ins.rb = prog[i-1].wd;
            if (seed_mode == 2) begin
                ins.is_load = 1'b1;
                if (i > 0) ins.ra = prog[i-1].wd;
            end
            prog.push_back(ins);
        end
        for (int i = 1; i < PROG_LEN; i++)
            if (prog[i-1].is_load && prog[i-1].wd != 0 &&
                (prog[i-1].wd == prog[i].ra || prog[i-1].wd == prog[i].rb))
                exp_stalls++;

        bub = '{is_load: 0, ra: 0, rb: 0, wd: 0, idx: -1};
        ifid = bub; idex = bub;
        while (issued.size() < PROG_LEN) begin
            @(posedge clk); #1;
            src_a = ifid.ra; src_b = ifid.rb; dst = idex.wd; mem_rd = idex.is_load;
            @(negedge clk);
            if (czero) begin
                got_stalls++;
                if (prev_stall) back_to_back++;
                idex = bub;
                prev_stall = 1;
            end else begin
                idex = ifid;
                if (ifid.idx >= 0) issued.push_back(ifid.idx);
                ifid = (pc < PROG_LEN) ? prog[pc] : bub;
                pc++;
                prev_stall = 0;
            end
        end
        for (int i = 0; i < PROG_LEN; i++)
            if (issued[i] != i) order_ok = 0;

        total++;
        if (got_stalls != exp_stalls) begin
            bad++;
            $display("FAIL R7 stall count mode=%0d: actual=%0d expected=%0d", seed_mode, got_stalls, exp_stalls);
        end
        total++;
        if (back_to_back != 0) begin
            bad++;
            $display("FAIL R7 consecutive stalls mode=%0d: actual=%0d expected=0", seed_mode, back_to_back);
        end
        total++;
        if (!order_ok) begin
            bad++;
            $display("FAIL R7 issue order mode=%0d: actual=mismatch expected=in-order", seed_mode);
        end
    endtask

    initial begin
        src_a = 0; src_b = 0; dst = 0; mem_rd = 0;
        // Quiet inputs: run state (R3)
        apply_vec(5'd0, 5'd0, 5'd0, 1'b0);
        // Directed cases
        apply_vec(5'd4, 5'd9, 5'd4, 1'b1);    // R1
        apply_vec(5'd9, 5'd4, 5'd4, 1'b1);    // R2
        apply_vec(5'd7, 5'd7, 5'd7, 1'b1);    // R1 and R2 together
        apply_vec(5'd4, 5'd4, 5'd4, 1'b0);    // R3
        apply_vec(5'd0, 5'd0, 5'd0, 1'b1);    // R4
        apply_vec(5'd0, 5'd3, 5'd0, 1'b1);    // R4
        apply_vec(5'd1, 5'd2, 5'd3, 1'b1);    // R5
        apply_vec(5'd31, 5'd30, 5'd31, 1'b1); // R1 top register
        apply_vec(5'd30, 5'd31, 5'd31, 1'b1); // R2 top register
        // Random vectors over a narrow register range to get frequent matches (R1..R6)
        for (int i = 0; i < 600; i++)
            apply_vec(5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)),
                      5'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
        for (int i = 0; i < 300; i++)
            apply_vec(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
        // Pipeline model runs (R7)
        run_program(0);
        run_program(1);
        run_program(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule